// File: doc/BRIEF.md
# Nine-Cycle Three-Word Minimal-Instruction Core

This block is a very small processor core built around one unified word memory, which sits inside the block. An instruction occupies three consecutive memory words. The first two words each carry one opcode bit and an operand address. The third word carries a signed branch displacement. The core runs every instruction through the same fixed sequence of nine main-clock cycles. It uses a program counter, an address register, an operand-A holding register, a result register and two opcode-bit registers. One adder is shared between the PC increments, the address loads and the branch target.

The block receives a clock at twice the main rate and halves it internally. All architectural registers change on the main clock's rising edge. The memory is read on the main clock's falling edge, so that its output is settled before the next rising edge. The opcode {first-word bit, second-word bit} selects one of four functions:

- GF(2^8) multiply
- bitwise XOR
- subtract-and-branch-if-negative
- truncation of an 11-bit word to its low 8 bits

The 8-bit result is written back to the second operand's address. A program is placed in memory through a load port while reset is held. After reset is released, the write-back port and the PC output show what the core does.

Top module: `misc_core`

## Requirements
- R1: While `rst_i` is high, `cyc_o` = 0, `pc_o` = 0, `mclk_o` = 0 and `wr_en_o` = 0.
- R2: `mclk_o` toggles on every `clk2x_i` edge. `cyc_o` steps 0,1,…,8,0 on each rising edge of `mclk_o`, so that every instruction after the first lasts exactly 18 `clk2x_i` cycles.
- R3: Instruction words 1 and 2 hold an opcode bit in bit 10 and an operand address in bits 9:0. The opcode is {word1[10], word2[10]}, with 00 = GF multiply, 01 = XOR, 10 = subtract-branch and 11 = truncate.
- R4: Each instruction makes exactly one memory write, during cycle 6. It writes to operand B's address, with bits 10:8 of the written word equal to zero.
- R5: Opcode 00 writes A·B in GF(2^8), reduced by x^8+x^4+x^3+x+1 (for example 0x57·0x83 = 0xC1).
- R6: Opcode 01 writes A XOR B.
- R7: Opcode 10 writes D = (B − A) mod 256. When D[7] = 1, the next PC is P + 3 + off (mod 1024), where P is the instruction address and off is word 3 bits 9:0. `branch_o` is high for exactly one sample of that instruction.
- R8: Opcode 11 writes the low 8 bits of operand B's 11-bit word and discards bits 10:8.
- R9: For any other opcode, and for opcode 10 with D[7] = 0, the next PC is P + 3 (mod 1024) and `branch_o` stays low.
- R10: Both instruction words and both operands are read before the write-back. The displacement word is read after it, so an instruction that overwrites its own third word branches by the new value.
- R11: `ld_en_i` has no effect on memory while `rst_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2x_i | input | 1 | Input clock at twice the main rate |
| rst_i | input | 1 | Synchronous active-high reset |
| ld_en_i | input | 1 | Preload write strobe, honoured only during reset |
| ld_addr_i | input | 10 | Preload word address |
| ld_word_i | input | 11 | Preload word |
| mclk_o | output | 1 | Main clock (input clock divided by two) |
| cyc_o | output | 4 | Current cycle number 0–8 |
| pc_o | output | 10 | Program counter |
| wr_en_o | output | 1 | Memory write-back strobe (falling half of cycle 6) |
| wr_addr_o | output | 10 | Write-back address |
| wr_data_o | output | 11 | Write-back word |
| branch_o | output | 1 | High in the half-cycle where a taken branch loads the PC |

## Verification
The assertions assume three things about the inputs:
- Reset is synchronous and held for at least one `clk2x_i` edge.
- Memory contents change only through the core's own write-back once reset is released.
- Any instruction word, including random data executed as code, is legal.

The stimulus preloads the whole memory under reset. Its code region mixes directed instructions with random ones, and every random operand address points into a randomly filled data area. After reset is released, the load strobe is held active only to show that it is ignored.

// File: rtl/misc_pkg.sv
package misc_pkg;

  localparam int DW = 8;
  localparam logic [DW-1:0] GF_RED = 8'h1B;

  typedef enum logic [1:0] {
    OP_GFM = 2'b00,
    OP_XOR = 2'b01,
    OP_SBN = 2'b10,
    OP_CVT = 2'b11
  } op_e;

  typedef enum logic [3:0] {
    S_PC1 = 4'd0,
    S_WD1 = 4'd1,
    S_OPA = 4'd2,
    S_PC2 = 4'd3,
    S_WD2 = 4'd4,
    S_EXE = 4'd5,
    S_WB  = 4'd6,
    S_OFF = 4'd7,
    S_INC = 4'd8
  } cyc_e;

  // shift-and-add multiply in GF(2^8)
  function automatic logic [DW-1:0] gf_mul(input logic [DW-1:0] a, input logic [DW-1:0] b);
    logic [DW-1:0] acc;
    logic [DW-1:0] x;
    acc = '0;
    x   = a;
    for (int i = 0; i < DW; i++) begin
      if (b[i]) acc = acc ^ x;
      x = {x[DW-2:0], 1'b0} ^ (x[DW-1] ? GF_RED : '0);
    end
    return acc;
  endfunction

  function automatic logic [DW-1:0] sbn_diff(input logic [DW-1:0] a, input logic [DW-1:0] b);
    return b - a;
  endfunction

endpackage

// File: rtl/misc_seq.sv
module misc_seq
  import misc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  output logic ph,
  output cyc_e cyc,
  output logic rise,
  output logic fall
);

  logic ph_q;
  cyc_e cyc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q  <= 1'b0;
      cyc_q <= S_PC1;
    end else begin
      ph_q <= ~ph_q;
      if (!ph_q) cyc_q <= (cyc_q == S_INC) ? S_PC1 : cyc_e'(4'(cyc_q) + 4'd1);
    end
  end

  assign ph   = ph_q;
  assign cyc  = cyc_q;
  assign rise = !rst && !ph_q;
  assign fall = !rst && ph_q;

  p_cyc_range_r2: assert property (@(posedge clk) disable iff (rst) 4'(cyc_q) <= 4'd8);

  p_cyc_step_r2: assert property (@(posedge clk) disable iff (rst)
    !ph_q |=> (4'(cyc_q) == ((4'($past(cyc_q)) == 4'd8) ? 4'd0 : 4'($past(cyc_q)) + 4'd1)));

  p_half_rate_r2: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ph_q != $past(ph_q));

  p_cyc_hold_r2: assert property (@(posedge clk) disable iff (rst)
    ph_q |=> $stable(cyc_q));

endmodule

// File: rtl/misc_exec.sv
module misc_exec
  import misc_pkg::*;
(
  input  op_e           op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] res,
  output logic          neg
);

  logic [DW-1:0] diff;

  assign diff = sbn_diff(a, b);
  assign neg  = diff[DW-1];

  always_comb begin
    unique case (op)
      OP_GFM:  res = gf_mul(a, b);
      OP_XOR:  res = a ^ b;
      OP_SBN:  res = diff;
      default: res = b;
    endcase
  end

endmodule

// File: rtl/misc_mem.sv
module misc_mem #(
  parameter int ADDR_W = 10,
  parameter int WORD_W = 11,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_en,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [WORD_W-1:0] ld_word,
  input  logic              fall,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata
);

  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      if (ld_en) mem[ld_addr] <= ld_word;
    end else if (fall && wr_en) begin
      mem[addr] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       rdata <= '0;
    else if (fall) rdata <= mem[addr];
  end

endmodule

// File: rtl/misc_core.sv
module misc_core
  import misc_pkg::*;
#(
  parameter int ADDR_W = 10,
  localparam int WORD_W = ADDR_W + 1
) (
  input  logic              clk2x_i,
  input  logic              rst_i,
  input  logic              ld_en_i,
  input  logic [ADDR_W-1:0] ld_addr_i,
  input  logic [WORD_W-1:0] ld_word_i,
  output logic              mclk_o,
  output logic [3:0]        cyc_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [WORD_W-1:0] wr_data_o,
  output logic              branch_o
);

  logic ph, rise, fall;
  cyc_e cyc;

  logic [ADDR_W-1:0] pc_q, mar_q;
  logic [DW-1:0]     opa_q, mdr_q;
  logic              opc1_q, opc0_q, n_q;
  logic [WORD_W-1:0] rdq;

  op_e           op;
  logic [DW-1:0] ex_res;
  logic          ex_neg;
  logic          take;
  logic          wb_now;

  logic [ADDR_W-1:0] add_b, add_sum;
  logic              add_cin;

  misc_seq u_seq (
    .clk (clk2x_i),
    .rst (rst_i),
    .ph  (ph),
    .cyc (cyc),
    .rise(rise),
    .fall(fall)
  );

  // shared adder: PC + displacement (cycle 7) or PC + carry-in
  assign add_b   = (cyc == S_OFF) ? rdq[ADDR_W-1:0] : '0;
  assign add_cin = (cyc == S_WD1) || (cyc == S_EXE) || (cyc == S_INC);
  assign add_sum = pc_q + add_b + ADDR_W'(add_cin);

  assign op   = op_e'({opc1_q, opc0_q});
  assign take = (op == OP_SBN) && n_q;

  misc_exec u_exec (
    .op (op),
    .a  (opa_q),
    .b  (rdq[DW-1:0]),
    .res(ex_res),
    .neg(ex_neg)
  );

  always_ff @(posedge clk2x_i) begin
    if (rst_i) begin
      pc_q   <= '0;
      mar_q  <= '0;
      opa_q  <= '0;
      mdr_q  <= '0;
      opc1_q <= 1'b0;
      opc0_q <= 1'b0;
      n_q    <= 1'b0;
    end else if (rise) begin
      unique case (cyc)
        S_PC1: mar_q <= add_sum;
        S_WD1: begin
          pc_q   <= add_sum;
          opc1_q <= rdq[ADDR_W];
          mar_q  <= rdq[ADDR_W-1:0];
        end
        S_OPA: opa_q <= rdq[DW-1:0];
        S_PC2: mar_q <= add_sum;
        S_WD2: begin
          opc0_q <= rdq[ADDR_W];
          mar_q  <= rdq[ADDR_W-1:0];
        end
        S_EXE: begin
          mdr_q <= ex_res;
          n_q   <= ex_neg;
          pc_q  <= add_sum;
        end
        S_WB:  mar_q <= add_sum;
        S_OFF: if (take) pc_q <= add_sum;
        default: pc_q <= add_sum;
      endcase
    end
  end

  assign wb_now = (cyc == S_WB);

  misc_mem #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_mem (
    .clk    (clk2x_i),
    .rst    (rst_i),
    .ld_en  (ld_en_i),
    .ld_addr(ld_addr_i),
    .ld_word(ld_word_i),
    .fall   (fall),
    .wr_en  (wb_now),
    .addr   (mar_q),
    .wdata  ({{(WORD_W-DW){1'b0}}, mdr_q}),
    .rdata  (rdq)
  );

  assign mclk_o    = ph;
  assign cyc_o     = 4'(cyc);
  assign pc_o      = pc_q;
  assign wr_en_o   = fall && wb_now;
  assign wr_addr_o = mar_q;
  assign wr_data_o = {{(WORD_W-DW){1'b0}}, mdr_q};
  assign branch_o  = rise && (cyc == S_OFF) && take;

  p_pc_hold_fall_r9: assert property (@(posedge clk2x_i) disable iff (rst_i)
    fall |=> $stable(pc_q));

  p_pc_inc_end_r2: assert property (@(posedge clk2x_i) disable iff (rst_i)
    (rise && cyc == S_INC) |=> pc_q == $past(pc_q) + ADDR_W'(1));

  p_word1_latch_r3: assert property (@(posedge clk2x_i) disable iff (rst_i)
    (rise && cyc == S_WD1) |=> (mar_q == $past(rdq[ADDR_W-1:0])) && (opc1_q == $past(rdq[ADDR_W])));

  p_branch_target_r7: assert property (@(posedge clk2x_i) disable iff (rst_i)
    branch_o |=> pc_q == $past(pc_q) + $past(rdq[ADDR_W-1:0]));

  p_no_branch_r9: assert property (@(posedge clk2x_i) disable iff (rst_i)
    (rise && cyc == S_OFF && !take) |=> $stable(pc_q));

  p_wb_mar_stable_r4: assert property (@(posedge clk2x_i) disable iff (rst_i)
    wr_en_o |-> $stable(mar_q));

endmodule

// File: tb/sim_misc_core.sv
module sim_misc_core;

  localparam int AW = 10;
  localparam int WW = 11;
  localparam int MAXI = 220;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ld_en = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [WW-1:0] ld_word = '0;
  logic          mclk, wr_en, branch;
  logic [3:0]    cyc;
  logic [AW-1:0] pc, wr_addr;
  logic [WW-1:0] wr_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic [WW-1:0] img [1024];
  logic [WW-1:0] mm  [1024];

  always #5 clk = ~clk;

  misc_core u0 (
    .clk2x_i(clk), .rst_i(rst), .ld_en_i(ld_en), .ld_addr_i(ld_addr), .ld_word_i(ld_word),
    .mclk_o(mclk), .cyc_o(cyc), .pc_o(pc), .wr_en_o(wr_en), .wr_addr_o(wr_addr),
    .wr_data_o(wr_data), .branch_o(branch)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // carry-less product followed by polynomial reduction from the top bit
  function automatic logic [7:0] ref_gf(input logic [7:0] a, input logic [7:0] b);
    logic [14:0] p;
    p = '0;
    for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (15'(a) << i);
    for (int i = 14; i >= 8; i--) if (p[i]) p = p ^ (15'h11B << (i - 8));
    return p[7:0];
  endfunction

  // one instruction of the model: returns write address, data, next pc, branch flag
  task automatic ref_step(input logic [AW-1:0] p, output logic [AW-1:0] wa,
                          output logic [7:0] wd, output logic [AW-1:0] np, output bit tk);
    logic [WW-1:0] w1, w2, w3;
    logic [7:0] a, b, d;
    logic [1:0] op;
    w1 = mm[p];
    a  = mm[w1[AW-1:0]][7:0];
    w2 = mm[AW'(p + 1)];
    b  = mm[w2[AW-1:0]][7:0];
    op = {w1[10], w2[10]};
    d  = b - a;
    case (op)
      2'b00: wd = ref_gf(a, b);
      2'b01: wd = a ^ b;
      2'b10: wd = d;
      default: wd = b;
    endcase
    wa = w2[AW-1:0];
    mm[wa] = {3'b000, wd};
    w3 = mm[AW'(p + 2)];
    tk = (op == 2'b10) && d[7];
    np = tk ? AW'(p + 3 + w3[AW-1:0]) : AW'(p + 3);
  endtask

  function automatic logic [WW-1:0] iw(input bit b, input int a);
    return {b, AW'(a)};
  endfunction

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 1024; i++) img[i] = WW'($urandom());
    for (int i = 33; i < 512; i++) begin
      if ((i - 33) % 3 == 2) img[i] = WW'($urandom_range(40) - 20);
      else img[i] = {1'($urandom()), 1'b1, 9'($urandom())};
    end
    for (int i = 0; i < 33; i++) img[i] = '0;
    img[0]  = iw(0, 600); img[1]  = iw(0, 601);
    img[3]  = iw(0, 602); img[4]  = iw(1, 603);
    img[6]  = iw(1, 605); img[7]  = iw(0, 604); img[8]  = 11'd3;
    img[12] = iw(1, 607); img[13] = iw(0, 608); img[14] = 11'h7F0;
    img[15] = iw(1, 600); img[16] = iw(1, 606);
    img[18] = iw(1, 605); img[19] = iw(0, 609); img[20] = 11'd6;
    img[24] = iw(0, 620); img[25] = iw(1, 610);
    img[27] = iw(1, 612); img[28] = iw(0, 611); img[29] = 11'h7FA;
    img[30] = iw(1, 613); img[31] = iw(0, 32);  img[32] = 11'h006;
    img[600] = 11'h057; img[601] = 11'h083; img[602] = 11'h0F0; img[603] = 11'h0AA;
    img[604] = 11'h010; img[605] = 11'h020; img[606] = 11'h7A5; img[607] = 11'h005;
    img[608] = 11'h005; img[609] = 11'h000; img[610] = 11'h000; img[611] = 11'h000;
    img[612] = 11'h080; img[613] = 11'h00A; img[620] = 11'h03C;
    for (int i = 0; i < 1024; i++) mm[i] = img[i];
  end

  initial begin
    int dwa [10] = '{601, 603, 604, 608, 606, 609, 611, 610, 611, 32};
    int dwd [10] = '{'hC1, 'h5A, 'hF0, 'h00, 'hA5, 'hE0, 'h80, 'h3C, 'h00, 'hFC};
    int dnp [10] = '{3, 6, 12, 15, 18, 27, 24, 27, 30, 285};
    string dtag [10] = '{"R5", "R6", "R7", "R9", "R8", "R7", "R7", "R11", "R9", "R10"};
    logic [AW-1:0] p, ewa, enp;
    logic [7:0] ewd;
    bit etk;
    int n, nw, nb;
    logic [AW-1:0] gwa;
    logic [WW-1:0] gwd;
    bit hung;

    @(negedge clk);
    ld_en = 1'b1;
    for (int i = 0; i < 1024; i++) begin
      ld_addr = AW'(i);
      ld_word = img[i];
      @(negedge clk);
    end
    ld_en = 1'b0;
    @(negedge clk);
    chk(cyc == 4'd0 && pc == '0 && mclk == 1'b0 && wr_en == 1'b0, "R1", {cyc, pc}, 0);
    // R11: keep the load strobe active during the run on a word read later
    ld_en = 1'b1; ld_addr = AW'(620); ld_word = 11'h7FF;
    rst = 1'b0;

    p = '0;
    hung = 0;
    for (int k = 0; k < MAXI && !hung; k++) begin
      ref_step(p, ewa, ewd, enp, etk);
      n = 0; nw = 0; nb = 0; gwa = '0; gwd = '0;
      forever begin
        @(negedge clk);
        n++;
        if (wr_en) begin nw++; gwa = wr_addr; gwd = wr_data; end
        if (branch) nb++;
        if (cyc == 4'd0 && mclk == 1'b1) break;
        if (n > 100) begin hung = 1; break; end
      end
      if (hung) begin
        chk(0, "R2 watchdog", n, 18);
      end else begin
        chk(n == ((k == 0) ? 17 : 18), "R2 cycle count", n, (k == 0) ? 17 : 18);
        chk(nw == 1 && gwa == ewa, "R4 write address", gwa, ewa);
        chk(gwd == {3'b000, ewd}, "R3 write data", gwd, {3'b000, ewd});
        chk(pc == enp, etk ? "R7 next pc" : "R9 next pc", pc, enp);
        chk(nb == (etk ? 1 : 0), "R7 branch strobe", nb, etk);
        if (k < 10) begin
          chk(gwa == AW'(dwa[k]) && gwd == WW'(dwd[k]) && pc == AW'(dnp[k]),
              dtag[k], {gwa, gwd}, {dwa[k][AW-1:0], WW'(dwd[k])});
        end
      end
      p = enp;
    end
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL R2 watchdog actual=%0h expected=%0h", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule